// File: doc/BRIEF.md
# Sparse-Tap Streaming Mean Filter

This block smooths a raster-order stream of disparity samples. For each pixel it averages 121 samples. They form an 11 by 11 grid with a pitch of three pixels, so together they cover a 31 by 31 pixel neighbourhood around the pixel. The result has the reach of a wide box filter for a fraction of the additions. Pixels arrive one per accepted clock with start-of-frame and end-of-line flags, and leave in the same order with the same flags.

Internally, ten circular line delays of three lines each present eleven sampled rows at once. Each row feeds a 31-deep horizontal shift register, and only every third stage of that register is tapped. A two-level registered adder tree (row sums, then total) feeds a reciprocal-multiply stage that divides by 121 with rounding. Pixels whose window would leave the frame are passed through unchanged. All storage advances only when the input valid is high, so the stream can pause at any cycle. Frame width and height are parameters; a 1280 by 720 stream uses `FRAME_W=1280, FRAME_H=720`.

Top module: `sparse_mean_filter`

## Requirements
- R1: After reset `outValid` is low, and it stays low until the first pixel of a frame supplied after reset has passed through the full latency.
- R2: For an interior pixel at (x, y), `outPixel` equals round-to-nearest of S/121, that is floor((S+60)/121). S is the sum of the input samples at (x+dx, y+dy) for dx and dy each in {-15,-12,...,0,...,12,15}.
- R3: Only samples whose horizontal and vertical distance from the centre is a multiple of three contribute; all other neighbours have no effect on the output.
- R4: A pixel with x<15, x>W-16, y<15 or y>H-16 is output with exactly its input value.
- R5: The k-th output (counted from 0, with frame 0 starting at the first accepted pixel after reset) appears in the cycle after the (k+15*W+18)-th accepted pixel (counted from 0), and it is the k-th pixel of the input stream.
- R6: `outSof` is high only on output pixel (0,0) of a frame and `outEol` only on x=W-1, so every output line holds exactly W pixels.
- R7: In a cycle after one with `inValid` low, `outValid` is low and `outPixel` holds its value; nothing is lost across the pause.
- R8: A frame at full scale (every sample 255) gives 255 at every interior pixel, with no wrap in the 15-bit sum.
- R9: With `inValid` held high, once the pipeline is primed one filtered pixel leaves on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input sample present; low stalls every stage |
| inPixel | input | 8 | Input disparity sample, unsigned |
| inSof | input | 1 | Marks the first pixel of a frame |
| inEol | input | 1 | Marks the last pixel of a line |
| outValid | output | 1 | Output sample present |
| outPixel | output | 8 | Smoothed or passed-through sample |
| outSof | output | 1 | First pixel of an output frame |
| outEol | output | 1 | Last pixel of an output line |

## Verification
The hardest state to reach is the one where a frame's interior pixels leave the pipe. This needs more than fifteen lines of the frame, plus the tail pulled through by later input, and the flow must keep its alignment across arbitrary valid gaps. The bench streams five consecutive frames with different content and gap spacing. The last frame only flushes the fourth. The bench checks every output of the first four frames against a model that rebuilds each sparse window from the generated pixels. A pseudo-random frame has neighbours that differ from the taps, so a window that used dense or shifted taps would produce different values.

// File: rtl/sparse_mean_pkg.sv
package sparse_mean_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic adv;      // accept a pixel, shift every stage
    logic edgeHit;  // current centre lies in the border band
    logic live;     // current centre is a real pixel of a frame
  } ctrlStrobes_t;
endpackage

// File: rtl/sparse_mean_ctrl.sv
module sparse_mean_ctrl
  import sparse_mean_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int FRAME_H = 40,
  parameter int HALF    = 15
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         nextCentreSof,
  output ctrlStrobes_t strobes
);
  localparam int COL_W = $clog2(FRAME_W);
  localparam int ROW_W = $clog2(FRAME_H);

  logic [COL_W-1:0] ctrCol;
  logic [ROW_W-1:0] ctrRow;
  logic             primed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrCol <= '0;
      ctrRow <= '0;
      primed <= 1'b0;
    end else if (inValid) begin
      if (nextCentreSof) begin
        ctrCol <= '0;
        ctrRow <= '0;
        primed <= 1'b1;
      end else if (ctrCol == COL_W'(FRAME_W - 1)) begin
        ctrCol <= '0;
        ctrRow <= (ctrRow == ROW_W'(FRAME_H - 1)) ? '0 : ctrRow + 1'b1;
      end else begin
        ctrCol <= ctrCol + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.adv     = inValid;
    strobes.live    = primed;
    strobes.edgeHit = (ctrCol < COL_W'(HALF)) || (ctrCol > COL_W'(FRAME_W - 1 - HALF)) ||
                      (ctrRow < ROW_W'(HALF)) || (ctrRow > ROW_W'(FRAME_H - 1 - HALF));
  end
endmodule

// File: rtl/sparse_mean_datapath.sv
module sparse_mean_datapath
  import sparse_mean_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int PIX_W   = 8,
  parameter int TAPS    = 11,
  parameter int STRIDE  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [PIX_W-1:0] inPixel,
  input  logic             inSof,
  input  logic             inEol,
  output logic             nextCentreSof,
  output logic             outValid,
  output logic [PIX_W-1:0] outPixel,
  output logic             outSof,
  output logic             outEol
);
  localparam int SPAN    = (TAPS - 1) * STRIDE + 1;
  localparam int HALF    = (TAPS - 1) * STRIDE / 2;
  localparam int CROW    = (TAPS - 1) / 2;
  localparam int DEPTH   = STRIDE * FRAME_W;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int WORD_W  = PIX_W + 2;
  localparam int MAXPIX  = (1 << PIX_W) - 1;
  localparam int RSUM_W  = $clog2(TAPS * MAXPIX + 1);
  localparam int SUM_W   = $clog2(TAPS * TAPS * MAXPIX + 1);
  localparam int NTAPS   = TAPS * TAPS;
  localparam int SHIFT   = 24;
  localparam longint RECIP = ((64'd1 << SHIFT) + NTAPS - 1) / NTAPS;
  localparam int RECIP_W = SHIFT + 1;
  localparam int PROD_W  = SUM_W + 1 + RECIP_W;

  logic [WORD_W-1:0] rowIn [TAPS];
  logic [WORD_W-1:0] win [TAPS][SPAN];
  logic [PTR_W-1:0]  ptr;

  assign rowIn[0] = {inEol, inSof, inPixel};

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (strobes.adv) ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  end

  // each sampled row lags the one above it by STRIDE full lines
  for (genvar r = 1; r < TAPS; r++) begin : g_line
    logic [WORD_W-1:0] mem [DEPTH];
    assign rowIn[r] = mem[ptr];
    always_ff @(posedge clk) begin
      if (strobes.adv) mem[ptr] <= rowIn[r-1];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.adv) begin
      for (int r = 0; r < TAPS; r++) begin
        win[r][0] <= rowIn[r];
        for (int c = 1; c < SPAN; c++) win[r][c] <= win[r][c-1];
      end
    end
  end

  assign nextCentreSof = win[CROW][HALF-1][PIX_W];

  // stage A: one sum per sampled row
  logic [RSUM_W-1:0] rowSumNext [TAPS];
  logic [RSUM_W-1:0] rowSumA [TAPS];
  logic [PIX_W-1:0]  pixA, pixB;
  logic              sofA, eolA, edgeA, liveA;
  logic              sofB, eolB, edgeB, liveB;
  logic [SUM_W-1:0]  totalNext, totalB;

  always_comb begin
    for (int r = 0; r < TAPS; r++) begin
      rowSumNext[r] = '0;
      for (int j = 0; j < TAPS; j++)
        rowSumNext[r] = rowSumNext[r] + RSUM_W'(win[r][j*STRIDE][PIX_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveA <= 1'b0;
    end else if (strobes.adv) begin
      for (int r = 0; r < TAPS; r++) rowSumA[r] <= rowSumNext[r];
      pixA  <= win[CROW][HALF][PIX_W-1:0];
      sofA  <= win[CROW][HALF][PIX_W];
      eolA  <= win[CROW][HALF][PIX_W+1];
      edgeA <= strobes.edgeHit;
      liveA <= strobes.live;
    end
  end

  // stage B: total of the row sums
  always_comb begin
    totalNext = '0;
    for (int r = 0; r < TAPS; r++) totalNext = totalNext + SUM_W'(rowSumA[r]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveB <= 1'b0;
    end else if (strobes.adv) begin
      totalB <= totalNext;
      pixB   <= pixA;
      sofB   <= sofA;
      eolB   <= eolA;
      edgeB  <= edgeA;
      liveB  <= liveA;
    end
  end

  // stage C: divide with rounding through a reciprocal product
  logic [PROD_W-1:0] prod;
  assign prod = PROD_W'({1'b0, totalB} + (SUM_W+1)'(NTAPS / 2)) * PROD_W'(RECIP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPixel <= '0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
    end else begin
      outValid <= strobes.adv && liveB;
      if (strobes.adv) begin
        outPixel <= edgeB ? pixB : prod[SHIFT +: PIX_W];
        outSof   <= sofB && liveB;
        outEol   <= eolB && liveB;
      end
    end
  end
endmodule

// File: rtl/sparse_mean_filter.sv
module sparse_mean_filter
  import sparse_mean_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int FRAME_H = 40,
  parameter int PIX_W   = 8,
  parameter int TAPS    = 11,
  parameter int STRIDE  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PIX_W-1:0] inPixel,
  input  logic             inSof,
  input  logic             inEol,
  output logic             outValid,
  output logic [PIX_W-1:0] outPixel,
  output logic             outSof,
  output logic             outEol
);
  localparam int HALF = (TAPS - 1) * STRIDE / 2;

  ctrlStrobes_t strobes;
  logic         nextCentreSof;

  sparse_mean_ctrl #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .HALF(HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .nextCentreSof(nextCentreSof), .strobes(strobes)
  );

  sparse_mean_datapath #(.FRAME_W(FRAME_W), .PIX_W(PIX_W), .TAPS(TAPS), .STRIDE(STRIDE)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inPixel(inPixel), .inSof(inSof), .inEol(inEol),
    .nextCentreSof(nextCentreSof),
    .outValid(outValid), .outPixel(outPixel), .outSof(outSof), .outEol(outEol)
  );
endmodule

// File: rtl/sparse_mean_checker.sv
module sparse_mean_checker #(
  parameter int FRAME_W = 48,
  parameter int PIX_W   = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic [PIX_W-1:0] outPixel,
  input logic             outSof,
  input logic             outEol
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  logic [CNT_W-1:0] lineCnt;

  always_ff @(posedge clk) begin
    if (!rstN) lineCnt <= '0;
    else if (outValid) lineCnt <= (outEol || outSof) ? (outSof && !outEol ? CNT_W'(1) : '0) : lineCnt + 1'b1;
  end

  // R7: a pause produces no output
  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R7: a pause leaves the output sample untouched
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outPixel));

  // R6: the two markers never share a pixel
  p_marker_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outSof |-> !outEol);

  // R6: end-of-line lands on the last pixel of a line
  p_line_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEol |-> lineCnt == CNT_W'(FRAME_W - 1));

  // R9: every output is the product of an accepted input
  p_out_needs_in_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
endmodule

bind sparse_mean_filter sparse_mean_checker #(.FRAME_W(FRAME_W), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outPixel(outPixel), .outSof(outSof), .outEol(outEol)
);

// File: tb/test_sparse_mean_filter.sv
module test_sparse_mean_filter;
  localparam int W = 40;
  localparam int H = 36;
  localparam int FRAME_PIX = W * H;
  localparam int LAT = 15 * W + 18;
  localparam int NFRAMES = 5;
  localparam int CHECKED = 4 * FRAME_PIX;
  // per frame: pattern id and gap spacing (0 = no gaps)
  localparam int PAT [NFRAMES] = '{0, 1, 2, 3, 0};
  localparam int GAP [NFRAMES] = '{0, 3, 0, 5, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inPixel = '0;
  logic inSof = 1'b0, inEol = 1'b0;
  logic outValid, outSof, outEol;
  logic [7:0] outPixel;

  int compared = 0, mismatched = 0;
  int acc = 0, outIdx = 0, cycles = 0;
  bit monitorOn = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sparse_mean_filter #(.FRAME_W(W), .FRAME_H(H)) i_sparse_mean_filter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPixel(inPixel),
    .inSof(inSof), .inEol(inEol), .outValid(outValid), .outPixel(outPixel),
    .outSof(outSof), .outEol(outEol)
  );

  function automatic int gen(int f, int x, int y);
    case (PAT[f])
      0: return 77;
      1: return 255;
      2: return (x * 5 + y * 3) & 255;
      default: return (((x * 37) ^ (y * 91) ^ (f * 53)) + x * y) & 255;
    endcase
  endfunction

  function automatic int model(int f, int x, int y);
    int s = 0;
    if (x < 15 || x > W - 16 || y < 15 || y > H - 16) return gen(f, x, y);
    for (int dy = -15; dy <= 15; dy += 3)
      for (int dx = -15; dx <= 15; dx += 3) s += gen(f, x + dx, y + dy);
    return (s + 60) / 121;
  endfunction

  task automatic check(string req, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d (output %0d)", req, got, exp, outIdx);
    end
  endtask

  // output monitor, sampling one time unit after the rising edge
  initial begin
    logic lastValid;
    logic [7:0] prevPix;
    forever begin
      @(posedge clk);
      lastValid = inValid;
      if (rstN && inValid) acc++;
      #1;
      if (monitorOn) begin
        if (!lastValid) begin
          check("R7 pause gives no output", int'(outValid), 0);
          check("R7 pause holds pixel", int'(outPixel), int'(prevPix));
        end else if (acc > LAT) begin
          check("R9 one output per accepted pixel", int'(outValid), 1);
        end else begin
          check("R1 quiet before fill", int'(outValid), 0);
        end
        if (outValid && outIdx < CHECKED) begin
          int f, x, y, req;
          f = outIdx / FRAME_PIX;
          x = (outIdx % FRAME_PIX) % W;
          y = (outIdx % FRAME_PIX) / W;
          check("R5 latency", acc - 1 - LAT, outIdx);
          check("R6 start marker", int'(outSof), int'(x == 0 && y == 0));
          check("R6 line marker", int'(outEol), int'(x == W - 1));
          req = (x < 15 || x > W - 16 || y < 15 || y > H - 16) ? 4 : (PAT[f] == 1 ? 8 : (PAT[f] == 3 ? 3 : 2));
          case (req)
            4: check("R4 border pass-through", int'(outPixel), model(f, x, y));
            8: check("R8 full scale mean", int'(outPixel), model(f, x, y));
            3: check("R3 sparse taps only", int'(outPixel), model(f, x, y));
            default: check("R2 rounded mean", int'(outPixel), model(f, x, y));
          endcase
        end
        if (outValid) outIdx++;
      end
      prevPix = outPixel;
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        mismatched++;
        compared++;
        $display("FAIL watchdog: got %0d cycles expected under 200000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  task automatic sendPixel(int f, int x, int y);
    @(negedge clk);
    inValid = 1'b1;
    inPixel = 8'(gen(f, x, y));
    inSof = (x == 0 && y == 0);
    inEol = (x == W - 1);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    inPixel = 8'hA5;
    inSof = 1'b1;
    inEol = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset output valid", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(outValid), 0);
    monitorOn = 1'b1;
    for (int f = 0; f < NFRAMES; f++) begin
      int n = 0;
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++) begin
          n++;
          if (GAP[f] != 0 && n % GAP[f] == 0) idle();
          sendPixel(f, x, y);
        end
    end
    idle();
    repeat (2) @(negedge clk);
    check("R5 outputs drained", outIdx, NFRAMES * FRAME_PIX - LAT);
    // R1: reset mid-stream clears the pipeline
    monitorOn = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset clears output", int'(outValid), 0);
    rstN = 1'b1;
    for (int i = 0; i < 100; i++) begin
      sendPixel(2, i % W, i / W);
      #2;
      if (outValid) check("R1 no output before new frame fills", int'(outValid), 0);
    end
    idle();
    @(negedge clk);
    check("R1 still quiet after short input", int'(outValid), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule